// File: doc/BRIEF.md
# CAN Controller Mode Control Register

This block is the mode-control register of a CAN-style peripheral. It keeps three control bits: module disable, freeze enable and halt. It also takes a debug-mode request from the system. From these it works out the operating mode of the peripheral: running, frozen or switched off.

Freeze and switch-off both wait for an idle handshake from the protocol engine before they take effect. The block drives four outputs from the mode:

- a not-ready status bit;
- a clock enable for the protocol engine and message-buffer logic;
- a permit for starting new receptions or transmissions;
- a gate that lets the CPU write the error-counter register.

A soft-reset input returns the register to its defaults but keeps the disable bit.

The mode is held in a five-state machine:

- `ST_RUN`: normal operation.
- `ST_FRZ_PEND`: freeze requested, waiting for the engine to go idle.
- `ST_FROZEN`: frozen.
- `ST_DIS_PEND`: disable requested, waiting for the engine to go idle.
- `ST_OFF`: module disabled, engine clock stopped.

The freeze request is `frz & (halt | dbg_req)`. The state machine reads the registered control bits, so a register write first acts on the clock after the one that stores it. Soft reset goes to `ST_OFF` when the disable bit is set and to `ST_FROZEN` otherwise.

Transitions, checked in the order given within each state:

- From `ST_RUN`:
  - disable set → `ST_DIS_PEND`;
  - otherwise freeze request → `ST_FRZ_PEND`.
- From `ST_FRZ_PEND`:
  - disable set → `ST_DIS_PEND`;
  - otherwise request dropped → `ST_RUN`;
  - otherwise engine idle → `ST_FROZEN`.
- From `ST_FROZEN`:
  - disable set → `ST_OFF` (the engine is already quiet);
  - otherwise request dropped → `ST_RUN`.
- From `ST_DIS_PEND`:
  - disable cleared → `ST_RUN`;
  - otherwise engine idle → `ST_OFF`.
- From `ST_OFF`:
  - disable cleared → `ST_RUN`.

Top module: `can_mode_ctrl`

## Requirements
- R1: After hardware reset the register reads 0x1A: disable 0, freeze-enable 1, halt 1, not-ready 1. The block is in `ST_FROZEN`, so `pe_clk_en`=1, `xfer_allow`=0 and `err_cnt_wr_en`=1.
- R2: A write with `reg_wr`=1 loads disable from bit 0, freeze-enable from bit 1 and halt from bit 3. Bit 4 (not-ready) and all other bits ignore writes. Reserved bits read 0, and bit 4 always reads the live not-ready state.
- R3: While `soft_rst`=1 at a clock edge, freeze-enable and halt are set to 1 and the disable bit keeps its value; a write on the same edge is dropped. The mode becomes `ST_OFF` if disable is 1 and `ST_FROZEN` otherwise.
- R4: A freeze request (freeze-enable and either halt or `dbg_req`) moves `ST_RUN` to `ST_FRZ_PEND`. The block stays there while `pe_idle`=0. Not-ready rises on the clock after `pe_idle` is seen at 1.
- R5: Clearing freeze-enable takes `ST_FROZEN` to `ST_RUN` on the next clock, even when halt or `dbg_req` is still 1.
- R6: Setting disable stops `pe_clk_en`. From `ST_FROZEN` this happens on the next clock; from `ST_RUN` or `ST_FRZ_PEND` it happens only after `pe_idle`=1 has been seen in `ST_DIS_PEND`. `pe_clk_en` is 0 only in `ST_OFF`.
- R7: In `ST_OFF` a freeze request has no effect. Clearing disable returns the block to `ST_RUN`, and a pending freeze request is then honoured from there.
- R8: `not_ready` and register bit 4 are 1 exactly in `ST_FROZEN` and `ST_OFF`.
- R9: `err_cnt_wr_en` is 1 only in `ST_FROZEN`.
- R10: `xfer_allow` is 1 only in `ST_RUN`. No reception or transmission may start while a freeze or disable is pending or in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; keeps the disable bit |
| reg_wr | input | 1 | Write strobe for the mode register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data: {27'b0, not-ready, halt, 0, freeze-enable, disable} |
| dbg_req | input | 1 | System debug-mode request |
| pe_idle | input | 1 | Protocol engine reports no frame in progress |
| pe_clk_en | output | 1 | Clock enable for the protocol engine and message buffers |
| xfer_allow | output | 1 | New receptions or transmissions may start |
| err_cnt_wr_en | output | 1 | CPU may write the error-counter register |
| not_ready | output | 1 | Module is frozen or disabled |

## Verification
The directed cases go after the following corner cases:

- Clearing freeze-enable while halt and debug are both still high. A design that keyed freeze exit on halt alone would stay frozen.
- A freeze or disable requested while the engine is busy. Entering early would raise not-ready a cycle or more too soon.
- Debug and freeze requests while disabled. A design that let these through would leave `ST_OFF` or grant error-counter writes.
- Soft reset with the disable bit set. Clearing it there would restart the engine clock.

Random writes, debug toggles, idle patterns and soft resets are then compared cycle by cycle against a model built from the transition list. This exposes wrong priorities and wrong register bit positions.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    // Register bit positions (decoded by software)
    localparam int unsigned BIT_DIS   = 0;
    localparam int unsigned BIT_FRZEN = 1;
    localparam int unsigned BIT_HALT  = 3;
    localparam int unsigned BIT_NRDY  = 4;
    localparam int unsigned MIN_W     = BIT_NRDY + 1;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_FRZ_PEND = 3'd1,
        ST_FROZEN   = 3'd2,
        ST_DIS_PEND = 3'd3,
        ST_OFF      = 3'd4
    } mode_e;

    typedef struct packed {
        logic dis;
        logic frz;
        logic halt;
    } ctrl_t;

endpackage

// File: rtl/can_mode_regs.sv
module can_mode_regs
    import can_mode_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              nrdy,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int unsigned PAD_W = DATA_W - MIN_W;

    ctrl_t ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.dis  <= 1'b0;
            ctrl_q.frz  <= 1'b1;
            ctrl_q.halt <= 1'b1;
        end else if (soft_rst) begin
            ctrl_q.frz  <= 1'b1;
            ctrl_q.halt <= 1'b1;
        end else if (reg_wr) begin
            ctrl_q.dis  <= reg_wdata[BIT_DIS];
            ctrl_q.frz  <= reg_wdata[BIT_FRZEN];
            ctrl_q.halt <= reg_wdata[BIT_HALT];
        end
    end

    assign ctrl = ctrl_q;

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[BIT_DIS]   = ctrl_q.dis;
        reg_rdata[BIT_FRZEN] = ctrl_q.frz;
        reg_rdata[BIT_HALT]  = ctrl_q.halt;
        reg_rdata[BIT_NRDY]  = nrdy;
    end

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[DATA_W-1:BIT_NRDY], reg_wdata[2], PAD_W[0]};

    // R3: soft reset keeps disable and restores freeze-enable and halt
    assert_softrst_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_q.dis == $past(ctrl_q.dis)) && ctrl_q.frz && ctrl_q.halt);

    // R2: without a strobe or soft reset the control bits hold
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !soft_rst) |=> $stable(ctrl_q));

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_rst,
    input  ctrl_t ctrl,
    input  logic  dbg_req,
    input  logic  pe_idle,
    output mode_e mode
);

    mode_e st_q, st_d;
    logic  frz_req;

    assign frz_req = ctrl.frz && (ctrl.halt || dbg_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_FROZEN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d = ctrl.dis ? ST_OFF : ST_FROZEN;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (ctrl.dis)    st_d = ST_DIS_PEND;
                    else if (frz_req) st_d = ST_FRZ_PEND;
                end
                ST_FRZ_PEND: begin
                    if (ctrl.dis)     st_d = ST_DIS_PEND;
                    else if (!frz_req) st_d = ST_RUN;
                    else if (pe_idle)  st_d = ST_FROZEN;
                end
                ST_FROZEN: begin
                    if (ctrl.dis)     st_d = ST_OFF;
                    else if (!frz_req) st_d = ST_RUN;
                end
                ST_DIS_PEND: begin
                    if (!ctrl.dis)   st_d = ST_RUN;
                    else if (pe_idle) st_d = ST_OFF;
                end
                ST_OFF: begin
                    if (!ctrl.dis)   st_d = ST_RUN;
                end
                default: st_d = ST_FROZEN;
            endcase
        end
    end

    assign mode = st_q;

    // R4: freeze taken one clock after idle is seen while pending
    assert_frz_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FRZ_PEND && !soft_rst && !ctrl.dis && frz_req && pe_idle) |=> st_q == ST_FROZEN);

    // R4: busy engine keeps freeze pending
    assert_frz_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FRZ_PEND && !soft_rst && !ctrl.dis && frz_req && !pe_idle) |=> st_q == ST_FRZ_PEND);

    // R5: dropping freeze-enable leaves freeze
    assert_frz_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FROZEN && !soft_rst && !ctrl.dis && !ctrl.frz) |=> st_q == ST_RUN);

    // R6: switch-off is reached only with disable set
    assert_off_needs_dis_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_OFF) |-> $past(ctrl.dis));

    // R7: freeze requests cannot pull the block out of switch-off
    assert_off_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && ctrl.dis && !soft_rst) |=> st_q == ST_OFF);

endmodule

// File: rtl/can_mode_outs.sv
module can_mode_outs
    import can_mode_pkg::*;
(
    input  mode_e mode,
    output logic  pe_clk_en,
    output logic  xfer_allow,
    output logic  err_cnt_wr_en,
    output logic  not_ready
);

    always_comb begin
        pe_clk_en     = 1'b1;
        xfer_allow    = 1'b0;
        err_cnt_wr_en = 1'b0;
        not_ready     = 1'b0;
        unique case (mode)
            ST_RUN:      xfer_allow = 1'b1;
            ST_FRZ_PEND: ;
            ST_DIS_PEND: ;
            ST_FROZEN: begin
                err_cnt_wr_en = 1'b1;
                not_ready     = 1'b1;
            end
            ST_OFF: begin
                pe_clk_en = 1'b0;
                not_ready = 1'b1;
            end
            default: not_ready = 1'b1;
        endcase
    end

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dbg_req,
    input  logic              pe_idle,
    output logic              pe_clk_en,
    output logic              xfer_allow,
    output logic              err_cnt_wr_en,
    output logic              not_ready
);

    ctrl_t ctrl;
    mode_e mode;

    can_mode_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .nrdy      (not_ready),
        .ctrl      (ctrl),
        .reg_rdata (reg_rdata)
    );

    can_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .ctrl     (ctrl),
        .dbg_req  (dbg_req),
        .pe_idle  (pe_idle),
        .mode     (mode)
    );

    can_mode_outs u_outs (
        .mode          (mode),
        .pe_clk_en     (pe_clk_en),
        .xfer_allow    (xfer_allow),
        .err_cnt_wr_en (err_cnt_wr_en),
        .not_ready     (not_ready)
    );

    // R9: error-counter writes only when frozen and clocked
    assert_ecnt_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt_wr_en |-> (not_ready && pe_clk_en));

    // R10: transfers never start while not ready
    assert_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_allow |-> (!not_ready && !err_cnt_wr_en));

    // R8: clock stopped implies not ready
    assert_nrdy_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_clk_en |-> not_ready);

endmodule

// File: tb/sim_can_mode_ctrl.sv
module sim_can_mode_ctrl;

    localparam int W = 32;
    localparam int M_RUN = 0, M_FP = 1, M_FRZ = 2, M_DP = 3, M_OFF = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_rst = 1'b0;
    logic         reg_wr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         dbg_req = 1'b0;
    logic         pe_idle = 1'b1;
    logic         pe_clk_en, xfer_allow, err_cnt_wr_en, not_ready;

    int n_chk = 0;
    int n_bad = 0;

    int m_st;
    bit m_dis, m_frz, m_halt;

    always #4 clk = ~clk;

    can_mode_ctrl #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dbg_req(dbg_req), .pe_idle(pe_idle), .pe_clk_en(pe_clk_en),
        .xfer_allow(xfer_allow), .err_cnt_wr_en(err_cnt_wr_en), .not_ready(not_ready)
    );

    function automatic int f_next(int st, bit dis, bit frz, bit halt,
                                  bit dbg, bit idle, bit srst);
        bit req;
        req = frz && (halt || dbg);
        if (srst) return dis ? M_OFF : M_FROZ();
        case (st)
            M_RUN: return dis ? M_DP : (req ? M_FP : M_RUN);
            M_FP:  return dis ? M_DP : (!req ? M_RUN : (idle ? M_FRZ : M_FP));
            M_FRZ: return dis ? M_OFF : (!req ? M_RUN : M_FRZ);
            M_DP:  return !dis ? M_RUN : (idle ? M_OFF : M_DP);
            default: return !dis ? M_RUN : M_OFF;
        endcase
    endfunction

    function automatic int M_FROZ();
        return M_FRZ;
    endfunction

    function automatic bit f_nrdy(int st);
        return (st == M_FRZ) || (st == M_OFF);
    endfunction

    function automatic logic [W-1:0] f_rdata(int st, bit dis, bit frz, bit halt);
        logic [W-1:0] v;
        v = '0;
        v[0] = dis; v[1] = frz; v[3] = halt; v[4] = f_nrdy(st);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic chk_all();
        chk("R2 reg_rdata", reg_rdata, f_rdata(m_st, m_dis, m_frz, m_halt));
        chk("R8 not_ready", {31'b0, not_ready}, {31'b0, f_nrdy(m_st)});
        chk("R6 pe_clk_en", {31'b0, pe_clk_en}, {31'b0, m_st != M_OFF});
        chk("R9 err_cnt_wr_en", {31'b0, err_cnt_wr_en}, {31'b0, m_st == M_FRZ});
        chk("R10 xfer_allow", {31'b0, xfer_allow}, {31'b0, m_st == M_RUN});
    endtask

    task automatic step();
        @(posedge clk);
        m_st = f_next(m_st, m_dis, m_frz, m_halt, dbg_req, pe_idle, soft_rst);
        if (soft_rst) begin
            m_frz = 1'b1; m_halt = 1'b1;
        end else if (reg_wr) begin
            m_dis = reg_wdata[0]; m_frz = reg_wdata[1]; m_halt = reg_wdata[3];
        end
        @(negedge clk);
        chk_all();
    endtask

    task automatic wr(input logic [W-1:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C4A));
        m_st = M_FRZ; m_dis = 0; m_frz = 1; m_halt = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", reg_rdata, 32'h1A);
        chk("R1 not_ready", {31'b0, not_ready}, 32'd1);
        chk("R1 clk_en", {31'b0, pe_clk_en}, 32'd1);
        chk("R1 ecnt", {31'b0, err_cnt_wr_en}, 32'd1);
        chk("R1 xfer", {31'b0, xfer_allow}, 32'd0);

        // R5: clear freeze-enable with halt and debug still set
        dbg_req = 1'b1;
        wr(32'h8);
        step();
        chk("R5 xfer", {31'b0, xfer_allow}, 32'd1);
        chk("R5 not_ready", {31'b0, not_ready}, 32'd0);
        dbg_req = 1'b0;

        // R4: freeze waits for idle
        pe_idle = 1'b0;
        wr(32'hA);
        step();
        step();
        chk("R4 pending not_ready", {31'b0, not_ready}, 32'd0);
        chk("R4 pending xfer", {31'b0, xfer_allow}, 32'd0);
        pe_idle = 1'b1;
        step();
        chk("R4 frozen not_ready", {31'b0, not_ready}, 32'd1);

        // R6: disable from frozen
        wr(32'h1);
        step();
        chk("R6 clk_en off", {31'b0, pe_clk_en}, 32'd0);
        chk("R6 rdata", reg_rdata, 32'h11);

        // R7: freeze request while off has no effect
        dbg_req = 1'b1;
        wr(32'hB);
        step();
        step();
        chk("R7 still off", {31'b0, pe_clk_en}, 32'd0);
        chk("R7 no ecnt", {31'b0, err_cnt_wr_en}, 32'd0);
        chk("R7 rdata", reg_rdata, 32'h1B);
        wr(32'hA);
        step();
        chk("R7 back to run clk_en", {31'b0, pe_clk_en}, 32'd1);
        chk("R7 back to run nrdy", {31'b0, not_ready}, 32'd0);
        step();
        step();
        chk("R7 frozen after enable", {31'b0, not_ready}, 32'd1);
        dbg_req = 1'b0;

        // R6: disable from run waits for idle
        wr(32'h0);
        step();
        pe_idle = 1'b0;
        wr(32'h1);
        step();
        step();
        chk("R6 pending clk_en", {31'b0, pe_clk_en}, 32'd1);
        pe_idle = 1'b1;
        step();
        chk("R6 off after idle", {31'b0, pe_clk_en}, 32'd0);

        // R3: soft reset keeps disable
        soft_rst = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0;
        step();
        soft_rst = 1'b0; reg_wr = 1'b0;
        chk("R3 rdata dis kept", reg_rdata, 32'h1B);
        chk("R3 clk_en", {31'b0, pe_clk_en}, 32'd0);
        wr(32'h0);
        step();
        soft_rst = 1'b1;
        step();
        soft_rst = 1'b0;
        chk("R3 rdata", reg_rdata, 32'h1A);
        chk("R3 frozen", {31'b0, err_cnt_wr_en}, 32'd1);

        // R2: reserved bits and bit 4 ignore writes
        wr(32'hFFFF_FFF4);
        chk("R2 reserved", reg_rdata, 32'h10);
        step();
        chk("R2 reserved run", reg_rdata, 32'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            reg_wr    = ($urandom % 6) == 0;
            reg_wdata = $urandom;
            dbg_req   = ($urandom % 4) == 0;
            pe_idle   = ($urandom % 2) == 0;
            soft_rst  = ($urandom % 40) == 0;
            step();
        end
        reg_wr = 1'b0; soft_rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule